// File: doc/BRIEF.md
# Region Protection and Cache Policy Checker

This block sits beside a processor's load/store and fetch paths and classifies every access before it reaches the caches. The 32-bit address space is cut into eight equal regions of 512 MB. For each region the block keeps a 4-bit attribute code in one of two tables: one table serves instruction fetches and the other serves data loads and stores. A single code sets both whether the access is permitted and how the cache treats it, and the same code means different things for a fetch, a load and a store.

For each request the block returns a policy code the same cycle: allocate, no-allocate, bypass, write-through without write allocate, write-back with write allocate, or direct access to the cache arrays. If the access is not permitted, it raises a fault flag instead. Software-side logic loads table entries through a simple write port, one entry per cycle. The caches, the memory system and the exception sequencing that reacts to the fault flag are outside the block.

Top module: `region_guard`

## Requirements
- R1: The region index is address bits [31:29]; address bits [28:0] have no effect on the result.
- R2: Access kind is encoded 00 fetch, 01 load, 10 store, 11 invalid. A fetch reads only the instruction table and a load or store reads only the data table. The result is combinational in the request inputs.
- R3: After reset every entry of both tables holds attribute code 0010.
- R4: When `wr_en_i` is 1 at a rising edge, entry `wr_idx_i` of the table chosen by `wr_tbl_i` (1 instruction, 0 data) takes `wr_mode_i`. A lookup in the same cycle still sees the old entry. Without a write, no entry changes.
- R5: Policy codes on `pol_o`: 0 allocate, 1 no-allocate, 2 bypass, 3 write-through/no write allocate, 4 write-back/write allocate, 5 direct cache array access. When `fault_o` is 1, `pol_o` is 7.
- R6: Code 0000 faults a fetch, gives no-allocate for a load and write-through for a store.
- R7: Code 0001 gives allocate for fetch and load and write-through for a store.
- R8: Code 0010 gives bypass for fetch, load and store.
- R9: Code 0011 faults a fetch, a load and a store.
- R10: Code 0100 gives allocate for fetch and load and write-back for a store.
- R11: Codes 0101 to 1101 and code 1111 fault every access kind.
- R12: Code 1110 faults a fetch and gives direct cache array access for a load or a store.
- R13: Access kind 11 faults for every attribute code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_addr_i | input | 32 | Request address |
| req_kind_i | input | 2 | Access kind: 00 fetch, 01 load, 10 store, 11 invalid |
| wr_en_i | input | 1 | Table write enable |
| wr_tbl_i | input | 1 | Table select: 1 instruction, 0 data |
| wr_idx_i | input | 3 | Region index written |
| wr_mode_i | input | 4 | Attribute code written |
| pol_o | output | 3 | Cache policy code |
| fault_o | output | 1 | Access not permitted |

## Verification
The policy and fault outputs depend only on the request inputs and the stored tables, so they are due in the same cycle as the request. The bench changes the request at a falling edge and samples 2 ns later, well before the next rising edge. A table write is due after exactly one rising edge. The bench checks it at the following falling edge, and it also checks a lookup to the written region in the write cycle itself, before the edge, where the old code must still be seen.

// File: rtl/rg_pkg.sv
package rg_pkg;

    typedef enum logic [1:0] {
        KIND_FETCH = 2'b00,
        KIND_LOAD  = 2'b01,
        KIND_STORE = 2'b10,
        KIND_BAD   = 2'b11
    } kind_e;

    typedef enum logic [2:0] {
        POL_ALLOC   = 3'd0,
        POL_NOALLOC = 3'd1,
        POL_BYPASS  = 3'd2,
        POL_WTHRU   = 3'd3,
        POL_WBACK   = 3'd4,
        POL_ISOLATE = 3'd5,
        POL_NONE    = 3'd7
    } pol_e;

    localparam int unsigned MODE_W = 4;

    localparam logic [MODE_W-1:0] CODE_NOALLOC = 4'b0000;
    localparam logic [MODE_W-1:0] CODE_WTHRU   = 4'b0001;
    localparam logic [MODE_W-1:0] CODE_BYPASS  = 4'b0010;
    localparam logic [MODE_W-1:0] CODE_WBACK   = 4'b0100;
    localparam logic [MODE_W-1:0] CODE_ISOLATE = 4'b1110;

endpackage

// File: rtl/rg_mode_table.sv
module rg_mode_table #(
    parameter int unsigned IDX_W    = 3,
    parameter int unsigned CODE_W   = 4,
    parameter logic [CODE_W-1:0] RST_CODE = 4'b0010
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [IDX_W-1:0]  wr_idx_i,
    input  logic [CODE_W-1:0] wr_code_i,
    input  logic [IDX_W-1:0]  rd_idx_i,
    output logic [CODE_W-1:0] rd_code_o
);

    localparam int unsigned ENTRIES = 1 << IDX_W;

    typedef struct packed {
        logic [ENTRIES-1:0][CODE_W-1:0] ent;
    } tbl_t;

    tbl_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en_i) begin
            st_d.ent[wr_idx_i] = wr_code_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.ent <= {ENTRIES{RST_CODE}};
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_code_o = st_q.ent[rd_idx_i];

    // R4
    wr_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_en_i |=> st_q.ent[$past(wr_idx_i)] == $past(wr_code_i));

    // R4
    no_wr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wr_en_i |=> $stable(st_q));

    // R3
    rst_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(rst_ni) == 1'b0) |-> (st_q.ent == {ENTRIES{RST_CODE}}));

endmodule

// File: rtl/rg_policy_decode.sv
module rg_policy_decode
    import rg_pkg::*;
(
    input  logic [MODE_W-1:0] code_i,
    input  logic [1:0]        kind_i,
    output logic [2:0]        pol_o,
    output logic              fault_o
);

    pol_e pol;

    always_comb begin
        pol = POL_NONE;
        unique case (kind_i)
            KIND_FETCH: begin
                unique case (code_i)
                    CODE_WTHRU, CODE_WBACK: pol = POL_ALLOC;
                    CODE_BYPASS:            pol = POL_BYPASS;
                    default:                pol = POL_NONE;
                endcase
            end
            KIND_LOAD: begin
                unique case (code_i)
                    CODE_NOALLOC:           pol = POL_NOALLOC;
                    CODE_WTHRU, CODE_WBACK: pol = POL_ALLOC;
                    CODE_BYPASS:            pol = POL_BYPASS;
                    CODE_ISOLATE:           pol = POL_ISOLATE;
                    default:                pol = POL_NONE;
                endcase
            end
            KIND_STORE: begin
                unique case (code_i)
                    CODE_NOALLOC, CODE_WTHRU: pol = POL_WTHRU;
                    CODE_BYPASS:              pol = POL_BYPASS;
                    CODE_WBACK:               pol = POL_WBACK;
                    CODE_ISOLATE:             pol = POL_ISOLATE;
                    default:                  pol = POL_NONE;
                endcase
            end
            default: pol = POL_NONE;
        endcase
    end

    assign pol_o   = pol;
    assign fault_o = (pol == POL_NONE);

endmodule

// File: rtl/region_guard.sv
module region_guard
    import rg_pkg::*;
#(
    parameter int unsigned ADDR_W      = 32,
    parameter int unsigned REGION_BITS = 3
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic [ADDR_W-1:0]      req_addr_i,
    input  logic [1:0]             req_kind_i,
    input  logic                   wr_en_i,
    input  logic                   wr_tbl_i,
    input  logic [REGION_BITS-1:0] wr_idx_i,
    input  logic [MODE_W-1:0]      wr_mode_i,
    output logic [2:0]             pol_o,
    output logic                   fault_o
);

    localparam int unsigned N_TBL   = 2;
    localparam int unsigned TBL_DAT = 0;
    localparam int unsigned TBL_INS = 1;

    logic [REGION_BITS-1:0] region;
    logic [MODE_W-1:0]      tbl_code [N_TBL];
    logic [MODE_W-1:0]      sel_code;

    assign region = req_addr_i[ADDR_W-1 -: REGION_BITS];

    for (genvar t = 0; t < N_TBL; t++) begin : g_tbl
        rg_mode_table #(
            .IDX_W    (REGION_BITS),
            .CODE_W   (MODE_W),
            .RST_CODE (CODE_BYPASS)
        ) u_tbl (
            .clk_i     (clk_i),
            .rst_ni    (rst_ni),
            .wr_en_i   (wr_en_i && (wr_tbl_i == 1'(t))),
            .wr_idx_i  (wr_idx_i),
            .wr_code_i (wr_mode_i),
            .rd_idx_i  (region),
            .rd_code_o (tbl_code[t])
        );
    end

    assign sel_code = (req_kind_i == KIND_FETCH) ? tbl_code[TBL_INS] : tbl_code[TBL_DAT];

    rg_policy_decode u_dec (
        .code_i  (sel_code),
        .kind_i  (req_kind_i),
        .pol_o   (pol_o),
        .fault_o (fault_o)
    );

    // R5
    fault_pol_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fault_o |-> pol_o == POL_NONE);

    // R12
    fetch_pol_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_kind_i == KIND_FETCH && !fault_o) |-> (pol_o == POL_ALLOC || pol_o == POL_BYPASS));

    // R6
    store_pol_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_kind_i == KIND_STORE) |-> (pol_o != POL_ALLOC && pol_o != POL_NOALLOC));

    // R13
    bad_kind_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_kind_i == KIND_BAD) |-> fault_o);

endmodule

// File: tb/region_guard_tb.sv
module region_guard_tb;

    logic        clk = 1'b0;
    logic        rst_ni = 1'b0;
    logic [31:0] req_addr_i = '0;
    logic [1:0]  req_kind_i = '0;
    logic        wr_en_i = 1'b0;
    logic        wr_tbl_i = 1'b0;
    logic [2:0]  wr_idx_i = '0;
    logic [3:0]  wr_mode_i = '0;
    logic [2:0]  pol_o;
    logic        fault_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [3:0] imod [8];
    logic [3:0] dmod [8];

    always #10 clk = ~clk;

    region_guard u_dut (
        .clk_i      (clk),
        .rst_ni     (rst_ni),
        .req_addr_i (req_addr_i),
        .req_kind_i (req_kind_i),
        .wr_en_i    (wr_en_i),
        .wr_tbl_i   (wr_tbl_i),
        .wr_idx_i   (wr_idx_i),
        .wr_mode_i  (wr_mode_i),
        .pol_o      (pol_o),
        .fault_o    (fault_o)
    );

    function automatic void model_of(input logic [3:0] m, input logic [1:0] k,
                                     output logic [2:0] p, output logic f);
        p = 3'd7;
        if (k == 2'd0) begin
            if (m == 4'd1 || m == 4'd4) p = 3'd0;
            else if (m == 4'd2)         p = 3'd2;
        end else if (k == 2'd1) begin
            if (m == 4'd0)                   p = 3'd1;
            else if (m == 4'd1 || m == 4'd4) p = 3'd0;
            else if (m == 4'd2)              p = 3'd2;
            else if (m == 4'd14)             p = 3'd5;
        end else if (k == 2'd2) begin
            if (m == 4'd0 || m == 4'd1) p = 3'd3;
            else if (m == 4'd2)         p = 3'd2;
            else if (m == 4'd4)         p = 3'd4;
            else if (m == 4'd14)        p = 3'd5;
        end
        f = (p == 3'd7);
    endfunction

    function automatic string tag_of(input logic [3:0] m, input logic [1:0] k);
        if (k == 2'd3) return "R13";
        case (m)
            4'd0:  return "R6";
            4'd1:  return "R7";
            4'd2:  return "R8";
            4'd3:  return "R9";
            4'd4:  return "R10";
            4'd14: return "R12";
            default: return "R11";
        endcase
    endfunction

    task automatic compare(input string tag, input logic [2:0] ep, input logic ef);
        checks++;
        if (pol_o !== ep || fault_o !== ef) begin
            fails++;
            $display("FAIL %s: addr=%h kind=%0d pol=%0d fault=%0d expected pol=%0d fault=%0d",
                     tag, req_addr_i, req_kind_i, pol_o, fault_o, ep, ef);
        end
    endtask

    // Drive a request at a falling edge and check 2 ns later against the shadow tables.
    task automatic lookup(input logic [1:0] k, input logic [31:0] a, input string extra);
        logic [3:0] m;
        logic [2:0] ep;
        logic       ef;
        @(negedge clk);
        req_kind_i = k;
        req_addr_i = a;
        #2;
        m = (k == 2'd0) ? imod[a[31:29]] : dmod[a[31:29]];
        model_of(m, k, ep, ef);
        compare({tag_of(m, k), extra}, ep, ef);
    endtask

    task automatic write_entry(input logic t, input logic [2:0] i, input logic [3:0] m);
        @(negedge clk);
        wr_en_i = 1'b1; wr_tbl_i = t; wr_idx_i = i; wr_mode_i = m;
        @(negedge clk);
        wr_en_i = 1'b0;
        if (t) imod[i] = m; else dmod[i] = m;
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not complete");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [2:0] ep;
        logic       ef;
        for (int i = 0; i < 8; i++) begin imod[i] = 4'd2; dmod[i] = 4'd2; end
        repeat (3) @(negedge clk);
        rst_ni = 1'b1;

        // R3: every region of both tables reads bypass after reset, kind 3 faults (R13)
        for (int r = 0; r < 8; r++) begin
            for (int k = 0; k < 4; k++) begin
                lookup(2'(k), {3'(r), 29'h0ABC_D12 + 29'(r)}, " R3");
            end
        end

        // R1: low address bits have no effect
        write_entry(1'b0, 3'd3, 4'd4);
        lookup(2'd2, {3'd3, 29'h0000_0000}, " R1");
        lookup(2'd2, {3'd3, 29'h1FFF_FFFF}, " R1");
        lookup(2'd2, {3'd2, 29'h1FFF_FFFF}, " R1");

        // R2/R4 sweep: every code in every region of each table, all kinds, plus a neighbour region
        for (int t = 0; t < 2; t++) begin
            for (int r = 0; r < 8; r++) begin
                for (int m = 0; m < 16; m++) begin
                    write_entry(1'(t), 3'(r), 4'(m));
                    for (int k = 0; k < 4; k++) begin
                        lookup(2'(k), {3'(r), 29'(m * 32'h0123_457 + t)}, " R2");
                    end
                    lookup(2'(m % 3), {3'((r + 1) % 8), 29'h155}, " R4");
                end
            end
        end

        // R4: a lookup in the write cycle sees the old code, the next cycle the new one
        write_entry(1'b0, 3'd5, 4'd2);
        @(negedge clk);
        wr_en_i = 1'b1; wr_tbl_i = 1'b0; wr_idx_i = 3'd5; wr_mode_i = 4'd14;
        req_kind_i = 2'd1; req_addr_i = {3'd5, 29'h10};
        #2;
        model_of(4'd2, 2'd1, ep, ef);
        compare("R4 same-cycle old", ep, ef);
        @(negedge clk);
        wr_en_i = 1'b0; dmod[5] = 4'd14;
        #2;
        model_of(4'd14, 2'd1, ep, ef);
        compare("R4 next-cycle new", ep, ef);

        // R2: a write to the instruction table leaves data lookups unchanged
        write_entry(1'b1, 3'd5, 4'd15);
        lookup(2'd2, {3'd5, 29'h20}, " R2");
        lookup(2'd0, {3'd5, 29'h20}, " R2");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule